// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block sits beside the receive shift register of an I2C target. After each START or repeated START it takes the first complete byte from the shift register and treats it as an address byte. It compares the upper seven bits of that byte with a programmed own address. When enabled, it also checks the whole byte against the general call value. It records the kind of hit and the direction bit. If the address hits and acknowledging is enabled, it drives the acknowledge for the ninth clock period.

The surrounding bus controller supplies single-cycle pulses for START, STOP, SCL falling edge and byte complete, and it supplies an abort pulse, for example when another wake source ends a low-power wait. The match outputs stay valid from the address decision until the next START, STOP or abort. A byte that arrives after the address byte, or while no transfer is open, has no effect. The data phase is outside this block.

Top module: `i2c_addr_match`

## Requirements
- R1: On the first byte_valid after a START, the unit sets match one cycle later when rx_byte[7:1] equals own_addr. It then sets rw to rx_byte[0] and keeps gc at 0, unless the byte is also a general call hit.
- R2: With gc_en high, a first byte equal to 8'h00 sets match and gc to 1 and rw to 0.
- R3: A general call attempt does not hit in two cases: gc_en is low, or the byte is 8'h01 (general call address with the read bit). In both cases match and gc stay 0 unless R1 applies.
- R4: With ack_en low, an address hit still sets match, but ack_drive stays 0.
- R5: After a hit with ack_en high, ack_drive is 1 from the cycle after byte_valid. It stays 1 until the first scl_fall pulse, and it is 0 from the cycle after that pulse.
- R6: A byte_valid pulse has no effect on match, gc, rw or ack_drive in two cases: it is not the first byte after a START, or it comes before any START.
- R7: A stop_det pulse clears match, gc, rw and ack_drive on the next cycle.
- R8: An abort pulse clears all outputs on the next cycle and returns the unit to idle. Abort takes priority over a START in the same cycle, so the next byte is then ignored.
- R9: A repeated START clears the previous result, and the next byte is evaluated as a new address byte.
- R10: After reset, match, gc, rw and ack_drive are 0 and bytes are ignored until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Programmed own 7-bit address |
| gc_en | input | 1 | Enables general call recognition |
| ack_en | input | 1 | Enables acknowledging a matched address |
| start_det | input | 1 | Pulse: START or repeated START seen |
| stop_det | input | 1 | Pulse: STOP seen |
| abort | input | 1 | Pulse: drop the transfer and go idle |
| scl_fall | input | 1 | Pulse: SCL falling edge |
| byte_valid | input | 1 | Pulse: rx_byte holds a complete byte |
| rx_byte | input | 8 | Byte from the receive shift register |
| match | output | 1 | Address hit (own or general call) |
| gc | output | 1 | The hit was a general call |
| rw | output | 1 | Direction bit of the hit address (1 = read) |
| ack_drive | output | 1 | Pull SDA low for the acknowledge |

## Verification
A wrong state register shows up at the ports within one cycle of the next byte_valid. If the unit has stayed in the address-waiting state, a data byte changes match or rw. If the unit has dropped out too early, the hit address is never reported. A stuck acknowledge state shows up as ack_drive still high one cycle after scl_fall. A missed clear shows up as match still high the cycle after stop_det or abort. The bench samples each of these exactly one cycle after the pulse that should cause the change.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          ack_en,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          abort,
  input  logic          scl_fall,
  input  logic          byte_valid,
  input  logic [AW:0]   rx_byte,
  output logic          match,
  output logic          gc,
  output logic          rw,
  output logic          ack_drive
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACK, S_HOLD} st_t;

  st_t  st;
  logic hit_own, hit_gc, hit;

  assign hit_own = (rx_byte[AW:1] == own_addr);
  assign hit_gc  = gc_en && (rx_byte == '0);
  assign hit     = hit_own || hit_gc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      match <= 1'b0;
      gc    <= 1'b0;
      rw    <= 1'b0;
    end else if (abort || stop_det) begin
      st    <= S_IDLE;
      match <= 1'b0;
      gc    <= 1'b0;
      rw    <= 1'b0;
    end else if (start_det) begin
      st    <= S_ADDR;
      match <= 1'b0;
      gc    <= 1'b0;
      rw    <= 1'b0;
    end else begin
      case (st)
        S_ADDR:
          if (byte_valid) begin
            match <= hit;
            gc    <= hit_gc;
            rw    <= hit && rx_byte[0];
            st    <= (hit && ack_en) ? S_ACK : S_HOLD;
          end
        S_ACK:
          if (scl_fall) st <= S_HOLD;
        default: st <= st;
      endcase
    end
  end

  assign ack_drive = (st == S_ACK);

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_en,
  input logic start_det,
  input logic stop_det,
  input logic abort,
  input logic scl_fall,
  input logic match,
  input logic gc,
  input logic rw,
  input logic ack_drive
);

  a_r5_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> match);

  a_r2_gc_is_write_match: assert property (@(posedge clk) disable iff (!rst_n)
    gc |-> (match && !rw));

  a_r4_ack_only_if_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> $past(ack_en));

  a_r5_ack_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && scl_fall) |=> !ack_drive);

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!match && !gc && !rw && !ack_drive));

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!match && !gc && !rw && !ack_drive));

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !start_det && !stop_det && !abort) |=> (match && $stable(rw) && $stable(gc)));

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!match && !ack_drive));

endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (.*);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] own_addr = 7'h50;
  logic       gc_en = 1'b0, ack_en = 1'b1;
  logic       start_det = 1'b0, stop_det = 1'b0, abort = 1'b0;
  logic       scl_fall = 1'b0, byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       match, gc, rw, ack_drive;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  i2c_addr_match dut_i (.*);

  // {gc_en, ack_en, own_addr[6:0], rx_byte[7:0], match, gc, rw, ack}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 7'h50, 8'hA0, 4'b1001},  // R1 write
    {1'b0, 1'b1, 7'h50, 8'hA1, 4'b1011},  // R1 read
    {1'b0, 1'b1, 7'h50, 8'hA2, 4'b0000},  // R1 miss
    {1'b1, 1'b1, 7'h50, 8'h00, 4'b1101},  // R2 general call
    {1'b0, 1'b1, 7'h50, 8'h00, 4'b0000},  // R3 gc disabled
    {1'b1, 1'b1, 7'h50, 8'h01, 4'b0000},  // R3 gc with read
    {1'b0, 1'b0, 7'h50, 8'hA1, 4'b1010},  // R4 no ack
    {1'b1, 1'b0, 7'h12, 8'h00, 4'b1100},  // R4 gc no ack
    {1'b1, 1'b1, 7'h7F, 8'hFE, 4'b1001}   // R1 top address
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {match,gc,rw,ack} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {match, gc, rw, ack_drive};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  task automatic pulse_fall();
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_byte = b; byte_valid = 1'b1; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", outs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'hA0);
    check("R10 byte before START ignored", outs(), 4'b0000);

    for (int i = 0; i < NV; i++) begin
      gc_en    = VEC[i][20];
      ack_en   = VEC[i][19];
      own_addr = VEC[i][18:12];
      pulse_start();
      send(VEC[i][11:4]);
      check($sformatf("R1-4 vector %0d", i), outs(), VEC[i][3:0]);
      @(negedge clk);
      check($sformatf("R5 hold vector %0d", i), outs(), VEC[i][3:0]);
      pulse_fall();
      check($sformatf("R5 ack end vector %0d", i), outs(), {VEC[i][3:1], 1'b0});
      pulse_stop();
      check($sformatf("R7 stop vector %0d", i), outs(), 4'b0000);
    end

    // R6: later bytes ignored, including while ack is driven
    gc_en = 1'b0; ack_en = 1'b1; own_addr = 7'h50;
    pulse_start();
    send(8'hA1);
    send(8'hA2);
    check("R6 byte during ack ignored", outs(), 4'b1011);
    pulse_fall();
    send(8'h00);
    check("R6 data byte ignored", outs(), 4'b1010);

    // R9: repeated START re-evaluates
    pulse_start();
    check("R9 start clears", outs(), 4'b0000);
    send(8'hA0);
    check("R9 new address", outs(), 4'b1001);
    pulse_fall();
    pulse_start();
    send(8'h22);
    check("R9 miss after restart", outs(), 4'b0000);

    // R8: abort with ack active, and abort beats start
    pulse_start();
    send(8'hA1);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    check("R8 abort clears", outs(), 4'b0000);
    @(negedge clk) begin abort = 1'b1; start_det = 1'b1; end
    @(negedge clk) begin abort = 1'b0; start_det = 1'b0; end
    send(8'hA1);
    check("R8 abort over start", outs(), 4'b0000);

    // R7: stop mid ack
    pulse_start();
    send(8'hA0);
    pulse_stop();
    check("R7 stop during ack", outs(), 4'b0000);
    send(8'hA0);
    check("R7 byte after stop ignored", outs(), 4'b0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule